// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block keeps the state of a set of interrupt sources on behalf of a small group of processors. For every interrupt ID it stores an enable bit, a pending bit, an active bit, a priority value with reduced precision, a trigger mode, and, for shared IDs, a mask of destination CPUs. Hardware interrupt lines are latched into the pending state according to each ID's trigger mode. Every ID that is enabled and pending drives the interrupt request of each CPU it targets, as long as the global forward switch is on.

Software reaches the state through a 32-bit word-addressed register bus. Writes take effect at the clock edge and reads are combinational. Enable and pending state each have a set bank and a clear bank. In both, only the bits written as one change state, so two agents can update disjoint bits without a read-modify-write. A per-CPU handshake is modelled as two request inputs. An acknowledge moves an ID from pending to active, and an end-of-service strobe retires it.

IDs 0 to 15 are software-only: their hardware lines are ignored. IDs 0 to 31 are private and go to every CPU. Shared IDs start at 32.

Top module: `irq_dist`

## Requirements
- R1: Bit 0 of the word at byte offset 0x000 is the forward switch (reset 0). `cpu_irq[c]` is high exactly when the switch is 1 and some ID is enabled, pending and targets CPU c. IDs below 32 target every CPU.
- R2: The enable state is reached through two banks, one bit per ID, with ID 32w+b at bit b of word w. A one written to the set bank (0x100) enables the ID. A one written to the clear bank (0x180) disables it. Zero bits leave the ID alone. Both banks read back the enable state. If set and clear happen together, clear wins. Reset is all disabled.
- R3: The pending state works the same way, with the set bank at 0x200 and the clear bank at 0x280. A clear overrides any set in the same cycle, whether the set comes from software or hardware.
- R4: The active state reads at 0x300 with the same bit layout. Writes there change nothing.
- R5: The priority bank at 0x400 holds one byte per ID, with ID 4w+k in byte k of word w. Only bits 7:3 are stored, so bits 2:0 read 0. Reset is 0.
- R6: The target bank at 0x800 holds one byte per ID with the same layout. Bit n of the byte routes the ID to CPU n. Bytes of IDs below 32 read all ones in the low NUM_CPU bits and ignore writes. Shared bytes reset to 0.
- R7: The configuration bank at 0xC00 holds 2 bits per ID, with ID 16w+k in bits 2k+1:2k of word w. IDs 0 to 15 always read 10. Other IDs read 01 for level mode (the reset value) and 11 for edge mode. Only the upper bit is writable.
- R8: In edge mode, a rising edge on `irq_in` sets pending. A line held high sets pending only once.
- R9: In level mode, a high `irq_in` sets pending in every cycle in which the ID is not active.
- R10: `irq_in` of IDs 0 to 15 has no effect.
- R11: `ack_valid` with a pending `ack_id` clears that ID's pending bit and sets its active bit at the next edge. An acknowledge of an ID that is not pending changes nothing.
- R12: `eoi_valid` clears the active bit of `eoi_id` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 12 | Byte address of the word, must be word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| irq_in | input | NUM_IRQ | Hardware interrupt lines, one per ID |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | $clog2(NUM_IRQ) | ID being acknowledged |
| eoi_valid | input | 1 | End-of-service strobe |
| eoi_id | input | $clog2(NUM_IRQ) | ID being retired |
| cpu_irq | output | NUM_CPU | Interrupt request per CPU |

## Verification
The bench builds the block with 64 IDs, 8 CPUs and 5 stored priority bits. With these values the state spans two words in each bit bank, so the word select of the set and clear banks is exercised beyond word 0. Every CPU has a full target byte. The configuration bank has one word fixed at 10 next to level and edge words, and the private/shared boundary at ID 32 falls inside the target bank, where fixed and writable bytes meet.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  localparam int SW_ONLY_IDS = 16;
  localparam int SHARED_BASE = 32;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_EN_SET, RG_EN_CLR, RG_PD_SET,
    RG_PD_CLR, RG_ACT, RG_PRIO, RG_TGT, RG_CFG
  } region_e;

  function automatic region_e decode_region(input logic [11:0] a);
    region_e r;
    r = RG_NONE;
    if (a[1:0] == 2'b00) begin
      if (a[11:10] == 2'b01)      r = RG_PRIO;
      else if (a[11:10] == 2'b10) r = RG_TGT;
      else if (a[11:8] == 4'hC)   r = RG_CFG;
      else if (a[11:8] == 4'h1)   r = a[7] ? RG_EN_CLR : RG_EN_SET;
      else if (a[11:8] == 4'h2)   r = a[7] ? RG_PD_CLR : RG_PD_SET;
      else if (a[11:8] == 4'h3)   r = a[7] ? RG_NONE : RG_ACT;
      else if (a[11:2] == 10'd0)  r = RG_CTRL;
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_dist_cell.sv
module irq_dist_cell #(
  parameter bit HW_IN  = 1'b1,
  parameter bit CFG_RW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic cfg_we,
  input  logic cfg_edge,
  input  logic en_set,
  input  logic en_clr,
  input  logic pd_set,
  input  logic pd_clr,
  input  logic ack,
  input  logic eoi,
  output logic en_q,
  output logic pd_q,
  output logic act_q,
  output logic edge_q
);

  logic prev_q;
  logic en_d, pd_d, act_d, edge_d, prev_d;
  logic hw_set, ack_hit;

  always_comb begin
    hw_set  = HW_IN & (edge_q ? (irq_in & ~prev_q) : (irq_in & ~act_q));
    ack_hit = ack & pd_q;
    en_d    = (en_q | en_set) & ~en_clr;
    pd_d    = (pd_q | pd_set | hw_set) & ~(pd_clr | ack_hit);
    act_d   = (act_q & ~eoi) | ack_hit;
    edge_d  = CFG_RW & (cfg_we ? cfg_edge : edge_q);
    prev_d  = HW_IN & irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pd_q   <= 1'b0;
      act_q  <= 1'b0;
      edge_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pd_q   <= pd_d;
      act_q  <= act_d;
      edge_q <= edge_d;
      prev_q <= prev_d;
    end
  end

  a_r2_clear_disables: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |=> !en_q);
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pd_clr |=> !pd_q);
  a_r11_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pd_q) |=> (act_q && !pd_q));
  a_r11_ack_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !pd_q && !act_q) |=> !act_q);
  a_r12_eoi_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(ack && pd_q)) |=> !act_q);

  if (HW_IN) begin : g_hw_chk
    a_r9_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_q && irq_in && !act_q && !pd_clr && !ack) |=> pd_q);
    a_r8_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_q && irq_in && !prev_q && !pd_clr && !ack) |=> pd_q);
  end else begin : g_sw_chk
    a_r10_line_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!pd_q && !pd_set) |=> !pd_q);
  end

endmodule

// File: rtl/irq_dist_route.sv
module irq_dist_route #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 8
) (
  input  logic                 gate,
  input  logic [NUM_IRQ-1:0]   live,
  input  logic [NUM_IRQ*8-1:0] tgt_flat,
  output logic [NUM_CPU-1:0]   cpu_irq
);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0] hit;
    always_comb begin
      for (int i = 0; i < NUM_IRQ; i++) hit[i] = live[i] & tgt_flat[i*8 + c];
    end
    assign cpu_irq[c] = gate & (|hit);
  end

endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_CPU   = 8,
  parameter int PRIO_BITS = 5,
  localparam int IDW      = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               ack_valid,
  input  logic [IDW-1:0]     ack_id,
  input  logic               eoi_valid,
  input  logic [IDW-1:0]     eoi_id,
  output logic [NUM_CPU-1:0] cpu_irq
);

  localparam int PAD = 8 - PRIO_BITS;

  region_e rg;
  logic [4:0] widx_bit;
  logic [7:0] widx_byte;
  logic [5:0] widx_cfg;
  logic fwd_q, fwd_d, fwd_we;

  logic [NUM_IRQ-1:0]   en_vec, pd_vec, act_vec;
  logic [NUM_IRQ*8-1:0] prio_flat, tgt_flat;
  logic [NUM_IRQ*2-1:0] cfg_flat;

  assign rg        = decode_region(bus_addr);
  assign widx_bit  = bus_addr[6:2];
  assign widx_byte = bus_addr[9:2];
  assign widx_cfg  = bus_addr[7:2];

  assign fwd_we = bus_wr && (rg == RG_CTRL);
  assign fwd_d  = fwd_we ? bus_wdata[0] : fwd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fwd_q <= 1'b0;
    else        fwd_q <= fwd_d;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
    logic bit_sel, byte_sel, cfg_sel, edge_q;
    logic [PRIO_BITS-1:0] pq;

    assign bit_sel  = bus_wr && (widx_bit == 5'(i / 32)) && bus_wdata[i % 32];
    assign byte_sel = bus_wr && (widx_byte == 8'(i / 4));
    assign cfg_sel  = bus_wr && (rg == RG_CFG) && (widx_cfg == 6'(i / 16));

    irq_dist_cell #(
      .HW_IN  (i >= SW_ONLY_IDS),
      .CFG_RW (i >= SW_ONLY_IDS)
    ) i_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in[i]),
      .cfg_we   (cfg_sel),
      .cfg_edge (bus_wdata[(i % 16) * 2 + 1]),
      .en_set   (bit_sel && (rg == RG_EN_SET)),
      .en_clr   (bit_sel && (rg == RG_EN_CLR)),
      .pd_set   (bit_sel && (rg == RG_PD_SET)),
      .pd_clr   (bit_sel && (rg == RG_PD_CLR)),
      .ack      (ack_valid && (ack_id == IDW'(i))),
      .eoi      (eoi_valid && (eoi_id == IDW'(i))),
      .en_q     (en_vec[i]),
      .pd_q     (pd_vec[i]),
      .act_q    (act_vec[i]),
      .edge_q   (edge_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          pq <= '0;
      else if (byte_sel && rg == RG_PRIO)  pq <= bus_wdata[(i % 4) * 8 + 7 -: PRIO_BITS];
    end
    assign prio_flat[i*8 +: 8] = {pq, {PAD{1'b0}}};

    if (i < SW_ONLY_IDS) begin : g_cfg_fix
      assign cfg_flat[i*2 +: 2] = 2'b10;
    end else begin : g_cfg_rw
      assign cfg_flat[i*2 +: 2] = {edge_q, 1'b1};
    end

    if (i < SHARED_BASE) begin : g_tgt_all
      assign tgt_flat[i*8 +: 8] = 8'({NUM_CPU{1'b1}});
    end else begin : g_tgt_rw
      logic [NUM_CPU-1:0] tq;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        tq <= '0;
        else if (byte_sel && rg == RG_TGT) tq <= bus_wdata[(i % 4) * 8 +: NUM_CPU];
      end
      assign tgt_flat[i*8 +: 8] = 8'(tq);
    end
  end

  always_comb begin
    unique case (rg)
      RG_CTRL:              bus_rdata = {31'd0, fwd_q};
      RG_EN_SET, RG_EN_CLR: bus_rdata = 32'(en_vec >> {widx_bit, 5'd0});
      RG_PD_SET, RG_PD_CLR: bus_rdata = 32'(pd_vec >> {widx_bit, 5'd0});
      RG_ACT:               bus_rdata = 32'(act_vec >> {widx_bit, 5'd0});
      RG_PRIO:              bus_rdata = 32'(prio_flat >> {widx_byte, 5'd0});
      RG_TGT:               bus_rdata = 32'(tgt_flat >> {widx_byte, 5'd0});
      RG_CFG:               bus_rdata = 32'(cfg_flat >> {widx_cfg, 5'd0});
      default:              bus_rdata = 32'd0;
    endcase
  end

  irq_dist_route #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) i_route (
    .gate     (fwd_q),
    .live     (en_vec & pd_vec),
    .tgt_flat (tgt_flat),
    .cpu_irq  (cpu_irq)
  );

  a_r1_switch_off: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_q |-> (cpu_irq == '0));
  a_r5_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rg == RG_PRIO) |-> (bus_rdata[PAD-1:0] == '0));
  a_r6_private_targets: assert property (@(posedge clk) disable iff (!rst_n)
    (rg == RG_TGT && widx_byte < 8'(SHARED_BASE / 4)) |-> (bus_rdata[NUM_CPU-1:0] == '1));
  a_r4_active_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && rg == RG_ACT && !ack_valid) |=> (act_vec == $past(act_vec) || $past(eoi_valid)));

endmodule

// File: tb/test_irq_dist.sv
module test_irq_dist;

  localparam int NI = 64;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NI-1:0] irq_in = '0;
  logic ack_valid = 1'b0;
  logic [5:0] ack_id = '0;
  logic eoi_valid = 1'b0;
  logic [5:0] eoi_id = '0;
  logic [NC-1:0] cpu_irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [63:0] en_m, pe_m;
  logic [7:0] tgt_m [NI];
  logic [7:0] prio_m [NI];

  always #2 clk = ~clk;

  irq_dist #(.NUM_IRQ(NI), .NUM_CPU(NC), .PRIO_BITS(5)) i_irq_dist (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_id(ack_id), .eoi_valid(eoi_valid),
    .eoi_id(eoi_id), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_ack(input int id);
    @(negedge clk);
    ack_valid = 1'b1; ack_id = 6'(id);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic do_eoi(input int id);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_id = 6'(id);
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_irq();
    logic [31:0] r = '0;
    for (int i = 0; i < NI; i++)
      if (en_m[i] && pe_m[i]) r[NC-1:0] |= tgt_m[i][NC-1:0];
    return r;
  endfunction

  function automatic logic [31:0] byte_word(input bit is_tgt, input int w);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = is_tgt ? tgt_m[4*w+k] : prio_m[4*w+k];
    return r;
  endfunction

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    int seed_val;
    seed_val = $urandom(32'd2024);
    en_m = '0; pe_m = '0;
    for (int i = 0; i < NI; i++) begin
      tgt_m[i] = (i < 32) ? 8'hFF : 8'h00;
      prio_m[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(12'h000, d); check("R1 reset switch", d, 32'h0);
    rd(12'h100, d); check("R2 reset enable", d, 32'h0);
    rd(12'hC00, d); check("R7 fixed cfg", d, 32'hAAAAAAAA);
    rd(12'hC08, d); check("R7 reset cfg", d, 32'h55555555);
    rd(12'h800, d); check("R6 private targets", d, 32'hFFFFFFFF);
    rd(12'h820, d); check("R6 reset shared target", d, 32'h0);
    check("R1 reset cpu_irq", 32'(cpu_irq), 32'h0);

    wr(12'h000, 32'h1);
    rd(12'h000, d); check("R1 switch on", d, 32'h1);

    // random register traffic with model
    for (int n = 0; n < 400; n++) begin
      int op, w;
      logic [31:0] v;
      op = int'($urandom % 6);
      v = $urandom;
      case (op)
        0: begin w = int'($urandom % 2); wr(12'h100 + 12'(4*w), v); en_m[w*32 +: 32] |= v;
             rd(12'h180 + 12'(4*w), d); check("R2 enable set", d, en_m[w*32 +: 32]); end
        1: begin w = int'($urandom % 2); wr(12'h180 + 12'(4*w), v); en_m[w*32 +: 32] &= ~v;
             rd(12'h100 + 12'(4*w), d); check("R2 enable clear", d, en_m[w*32 +: 32]); end
        2: begin w = int'($urandom % 2); wr(12'h200 + 12'(4*w), v); pe_m[w*32 +: 32] |= v;
             rd(12'h280 + 12'(4*w), d); check("R3 pending set", d, pe_m[w*32 +: 32]); end
        3: begin w = int'($urandom % 2); wr(12'h280 + 12'(4*w), v); pe_m[w*32 +: 32] &= ~v;
             rd(12'h200 + 12'(4*w), d); check("R3 pending clear", d, pe_m[w*32 +: 32]); end
        4: begin w = int'($urandom % 16); wr(12'h400 + 12'(4*w), v);
             for (int k = 0; k < 4; k++) prio_m[4*w+k] = v[k*8 +: 8] & 8'hF8;
             rd(12'h400 + 12'(4*w), d); check("R5 priority", d, byte_word(1'b0, w)); end
        default: begin w = 8 + int'($urandom % 8); wr(12'h800 + 12'(4*w), v);
             for (int k = 0; k < 4; k++) tgt_m[4*w+k] = v[k*8 +: 8];
             rd(12'h800 + 12'(4*w), d); check("R6 target", d, byte_word(1'b1, w)); end
      endcase
      check("R1 forwarding", 32'(cpu_irq), exp_irq());
    end

    // private target writes ignored
    wr(12'h804, 32'h0);
    rd(12'h804, d); check("R6 private write ignored", d, 32'hFFFFFFFF);

    // clean state
    wr(12'h180, '1); wr(12'h184, '1); wr(12'h280, '1); wr(12'h284, '1);
    en_m = '0; pe_m = '0;
    check("R1 idle", 32'(cpu_irq), 32'h0);

    // R4 active is read only
    wr(12'h300, '1);
    rd(12'h300, d); check("R4 active write ignored", d, 32'h0);

    // R5 low bits
    wr(12'h428, 32'hFFFFFFFF);
    rd(12'h428, d); check("R5 low bits zero", d, 32'hF8F8F8F8);

    // R7 configuration
    wr(12'hC00, 32'h55555555);
    rd(12'hC00, d); check("R7 fixed cfg write ignored", d, 32'hAAAAAAAA);
    wr(12'hC08, 32'h0);
    rd(12'hC08, d); check("R7 low bit read only", d, 32'h55555555);
    wr(12'hC08, 32'h55575555);
    rd(12'hC08, d); check("R7 edge mode id 40", d, 32'h55575555);

    // R8 edge id 40 (pending word 1 bit 8)
    @(negedge clk); irq_in[40] = 1'b1;
    rd(12'h204, d); check("R8 edge sets pending", 32'(d[8]), 32'h1);
    wr(12'h284, 32'h100);
    rd(12'h204, d); check("R8 held line sets once", 32'(d[8]), 32'h0);
    @(negedge clk); irq_in[40] = 1'b0;

    // R9 level id 41 (bit 9)
    @(negedge clk); irq_in[41] = 1'b1;
    rd(12'h204, d); check("R9 level sets pending", 32'(d[9]), 32'h1);
    wr(12'h284, 32'h200);
    rd(12'h204, d); check("R9 level re-pends", 32'(d[9]), 32'h1);
    do_ack(41);
    rd(12'h304, d); check("R11 ack sets active", 32'(d[9]), 32'h1);
    rd(12'h204, d); check("R11 ack clears pending", 32'(d[9]), 32'h0);
    repeat (3) @(negedge clk);
    rd(12'h204, d); check("R9 active blocks level", 32'(d[9]), 32'h0);
    do_eoi(41);
    rd(12'h304, d); check("R12 eoi clears active", 32'(d[9]), 32'h0);
    rd(12'h204, d); check("R9 level after eoi", 32'(d[9]), 32'h1);
    @(negedge clk); irq_in[41] = 1'b0;
    wr(12'h284, 32'h200);

    // R10 software-only line ignored
    @(negedge clk); irq_in[3] = 1'b1;
    repeat (2) @(negedge clk);
    rd(12'h200, d); check("R10 line of id 3 ignored", 32'(d[3]), 32'h0);
    @(negedge clk); irq_in[3] = 1'b0;

    // R11 ack of non-pending id 50
    do_ack(50);
    rd(12'h304, d); check("R11 ack without pending", 32'(d[18]), 32'h0);

    // R1 private id to every cpu, shared id to its mask
    wr(12'h100, 32'h20); wr(12'h200, 32'h20);
    check("R1 private to all", 32'(cpu_irq), 32'hFF);
    wr(12'h000, 32'h0);
    check("R1 switch off", 32'(cpu_irq), 32'h0);
    wr(12'h000, 32'h1);
    wr(12'h180, 32'h20);
    wr(12'h820, 32'h00000400);
    wr(12'h104, 32'h2); wr(12'h204, 32'h2);
    check("R1 shared to mask", 32'(cpu_irq), 32'h04);
    do_ack(33);
    check("R11 acked id stops request", 32'(cpu_irq), 32'h0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule